// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block works out how many master-clock cycles make up one word-clock period. It snaps that count to one of six fixed ratios, so the audio datapath can select its filter and noise-shaper timing. The word clock arrives from outside and has no fixed phase relation to the master clock. It is brought into the master-clock domain through a two-flop synchroniser. A period is then measured as the number of master clocks between two successive synchronised rising edges.

A measured period matches a ratio when it lies within 32 master clocks of that ratio, with both ends of the window included. When no window holds the count, the block falls back to the 768 ratio and raises an error. A new classification reaches the output only after two consecutive periods agree, so a single jittered or truncated period does not disturb the result. In master mode, measurement is bypassed: a programmed rate field selects the ratio directly and the word clock has no effect. Next to the ratio code, the block reports two things: whether the DAC path must run at 64 fs oversampling, and whether the current ratio cannot be used by an active ADC. A separate force bit puts the ADC path into 64 fs regardless of the ratio.

The confirmation engine has four states. `ST_IDLE`: after reset, or while master mode is held, the state machine stays here. Its first completed period is thrown away and the machine moves to `ST_PRIME`. `ST_PRIME`: the next completed period stores its class as the candidate and the machine moves to `ST_CONFIRM`. `ST_CONFIRM`: a completed period whose class equals the candidate is committed to the output and the machine moves to `ST_LOCKED`. A period whose class differs replaces the candidate and the machine stays in `ST_CONFIRM`. `ST_LOCKED`: a completed period whose class differs from the committed one becomes the candidate and the machine returns to `ST_CONFIRM`. A matching period keeps it in `ST_LOCKED`. Master mode sends every state back to `ST_IDLE`.

Top module: `mclk_ratio_detect`

## Requirements
- R1: In slave mode, a steady word clock whose rising edges are N master clocks apart is classified from N. The ratio code values are 0 = 128, 1 = 192, 2 = 256, 3 = 384, 4 = 512 and 5 = 768.
- R2: A count matches a ratio R when R-32 <= N <= R+32. Where two windows touch (N = 160 or N = 224), the smaller ratio wins.
- R3: A count that matches no window, including a saturated count, gives code 5 with ratio_err high.
- R4: The slave-mode code changes only after two consecutive measured periods classify to the same new value. A single differing period leaves the code unchanged.
- R5: In master mode, ratio_code equals rate_sel for values 0 to 5, while rate_sel values 6 and 7 give code 5 with ratio_err high. Word-clock activity has no effect in this mode.
- R6: dac_osr_64 is high exactly when ratio_code is 0 or 1.
- R7: ratio_err is high whenever adc_active is high and ratio_code is 0 or 1.
- R8: adc_osr_64 follows adc_osr_force and does not depend on the ratio.
- R9: After reset, ratio_code is 5 while ratio_err and dac_osr_64 are low.
- R10: After leaving master mode, the first completed word-clock period is discarded. The committed code is kept until two later periods agree.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wclk | input | 1 | Word clock, asynchronous to clk |
| master_mode | input | 1 | 1 = programmed rate, 0 = automatic detection |
| rate_sel | input | 3 | Programmed ratio code used in master mode |
| adc_active | input | 1 | ADC path is in use |
| adc_osr_force | input | 1 | Force ADC path oversampling to 64 fs |
| ratio_code | output | 3 | Selected master-clock ratio code |
| dac_osr_64 | output | 1 | DAC oversampling is 64 fs (else 128 fs) |
| adc_osr_64 | output | 1 | ADC oversampling is 64 fs (else 128 fs) |
| ratio_err | output | 1 | Default ratio used, invalid rate field, or ratio unusable for the ADC |

## Verification
Several properties are checked on every cycle. A measurement follows every synchronised rising edge. The committed code changes only on an agreeing period in the confirm state. The error flag accompanies both the no-match default and a low ratio while the ADC is active. The master-mode output holds steady while the rate field is steady. Other behaviour can only be shown by the bench scenarios: the exact window edges, the lower-ratio priority where windows touch, rejection of a lone outlier period, and the discarded first period after master mode ends. All of these depend on driving specific sequences of word-clock periods.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    localparam int NUM_RATIOS = 6;
    localparam int CODE_W     = 3;

    typedef logic [CODE_W-1:0] ratio_code_t;

    localparam ratio_code_t CODE_192     = 3'd1;
    localparam ratio_code_t CODE_768     = 3'd5;
    localparam ratio_code_t CODE_NOMATCH = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRIME,
        ST_CONFIRM,
        ST_LOCKED
    } det_state_e;

    function automatic int ratio_value(input int idx);
        case (idx)
            0:       return 128;
            1:       return 192;
            2:       return 256;
            3:       return 384;
            4:       return 512;
            default: return 768;
        endcase
    endfunction

endpackage

// File: rtl/mrd_wclk_sync.sv
module mrd_wclk_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wclk_async,
    output logic rise_o
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= wclk_async;
            for (int i = 1; i < CHAIN_W; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise_i,
    output logic [CNT_W-1:0] period_cnt_o,
    output logic             period_done_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q         <= '0;
            period_cnt_o  <= '0;
            period_done_o <= 1'b0;
        end else if (rise_i) begin
            period_cnt_o  <= run_q;
            period_done_o <= 1'b1;
            run_q         <= CNT_W'(1);
        end else begin
            period_done_o <= 1'b0;
            if (run_q != CNT_MAX) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R1: every synchronised rising edge yields a completed measurement
    p_done_follows_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |=> period_done_o);

endmodule

// File: rtl/mrd_ratio_classifier.sv
module mrd_ratio_classifier
    import mrd_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int TOL   = 32
) (
    input  logic [CNT_W-1:0] cnt_i,
    output ratio_code_t      cls_o
);

    logic [NUM_RATIOS-1:0] hit;

    for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
        localparam int LO = ratio_value(g) - TOL;
        localparam int HI = ratio_value(g) + TOL;
        assign hit[g] = (32'(cnt_i) >= LO) && (32'(cnt_i) <= HI);
    end

    always_comb begin
        cls_o = CODE_NOMATCH;
        for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                cls_o = ratio_code_t'(i);
            end
        end
    end

endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
    import mrd_pkg::*;
#(
    parameter int CNT_W       = 11,
    parameter int TOL         = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wclk,
    input  logic       master_mode,
    input  logic [2:0] rate_sel,
    input  logic       adc_active,
    input  logic       adc_osr_force,
    output logic [2:0] ratio_code,
    output logic       dac_osr_64,
    output logic       adc_osr_64,
    output logic       ratio_err
);

    logic             wclk_rise;
    logic [CNT_W-1:0] period_cnt;
    logic             period_done;
    ratio_code_t      cls;

    det_state_e  state_q, state_d;
    ratio_code_t cand_q, det_q;

    mrd_wclk_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .wclk_async (wclk),
        .rise_o     (wclk_rise)
    );

    mrd_period_counter #(.CNT_W(CNT_W)) u_count (
        .clk           (clk),
        .rst_n         (rst_n),
        .rise_i        (wclk_rise),
        .period_cnt_o  (period_cnt),
        .period_done_o (period_done)
    );

    mrd_ratio_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_class (
        .cnt_i (period_cnt),
        .cls_o (cls)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (master_mode) begin
            state_d = ST_IDLE;
        end else if (period_done) begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_PRIME;
                ST_PRIME:   state_d = ST_CONFIRM;
                ST_CONFIRM: state_d = (cls == cand_q) ? ST_LOCKED : ST_CONFIRM;
                ST_LOCKED:  state_d = (cls == det_q) ? ST_LOCKED : ST_CONFIRM;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // candidate and committed class
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q <= CODE_768;
            det_q  <= CODE_768;
        end else if (!master_mode && period_done) begin
            unique case (state_q)
                ST_IDLE: ;
                ST_PRIME: cand_q <= cls;
                ST_CONFIRM: begin
                    if (cls == cand_q) begin
                        det_q <= cls;
                    end else begin
                        cand_q <= cls;
                    end
                end
                ST_LOCKED: begin
                    if (cls != det_q) begin
                        cand_q <= cls;
                    end
                end
            endcase
        end
    end

    // outputs
    logic slave_miss;
    logic master_bad;

    always_comb begin
        slave_miss = (det_q == CODE_NOMATCH);
        master_bad = (rate_sel > CODE_768);
        if (master_mode) begin
            ratio_code = master_bad ? CODE_768 : rate_sel;
        end else begin
            ratio_code = slave_miss ? CODE_768 : det_q;
        end
        dac_osr_64 = (ratio_code <= CODE_192);
        adc_osr_64 = adc_osr_force;
        ratio_err  = (master_mode ? master_bad : slave_miss)
                   | (adc_active & dac_osr_64);
    end

    // R4: committed class changes only on an agreeing period while confirming
    p_commit_on_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (det_q != $past(det_q)) |->
            ($past(state_q) == ST_CONFIRM && $past(period_done) && !$past(master_mode)));

    // R3: outside master mode and without the ADC, an error means the default ratio
    p_default_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && !adc_active && ratio_err) |-> (ratio_code == CODE_768));

    // R5: master mode output does not move while the rate field is steady
    p_master_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && $past(master_mode) && $stable(rate_sel)) |-> $stable(ratio_code));

    // R7: a low ratio with the ADC active is always flagged
    p_adc_low_ratio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_active && ratio_code <= CODE_192) |-> ratio_err);

    // R6: 64 fs DAC oversampling only for the two lowest ratios
    p_dac_osr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dac_osr_64 |-> (ratio_code <= CODE_192));

endmodule

// File: tb/test_mclk_ratio_detect.sv
`timescale 1ns/1ps
module test_mclk_ratio_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wclk = 1'b0;
    logic       master_mode = 1'b0;
    logic [2:0] rate_sel = 3'd0;
    logic       adc_active = 1'b0;
    logic       adc_osr_force = 1'b0;
    logic [2:0] ratio_code;
    logic       dac_osr_64;
    logic       adc_osr_64;
    logic       ratio_err;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    mclk_ratio_detect i_mclk_ratio_detect (
        .clk           (clk),
        .rst_n         (rst_n),
        .wclk          (wclk),
        .master_mode   (master_mode),
        .rate_sel      (rate_sel),
        .adc_active    (adc_active),
        .adc_osr_force (adc_osr_force),
        .ratio_code    (ratio_code),
        .dac_osr_64    (dac_osr_64),
        .adc_osr_64    (adc_osr_64),
        .ratio_err     (ratio_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_outs(input string req, input int code, input int err, input int dosr);
        chk({req, " code"}, ratio_code, code);
        chk({req, " err"}, ratio_err, err);
        chk({req, " dac_osr"}, dac_osr_64, dosr);
    endtask

    // one word-clock period of n master clocks; the rise opens the period
    task automatic blocks(input int n, input int k);
        for (int b = 0; b < k; b++) begin
            @(negedge clk) wclk = 1'b1;
            repeat (8) @(negedge clk);
            wclk = 1'b0;
            repeat (n - 9) @(negedge clk);
        end
        #1;
    endtask

    task automatic t_reset;
        chk_outs("R9 reset", 5, 0, 0);
    endtask

    task automatic t_lock_basic;
        blocks(256, 5);
        chk_outs("R1 256", 2, 0, 0);
        adc_active = 1'b1; #1;
        chk("R7 256 adc ok", ratio_err, 0);
        adc_active = 1'b0;
        blocks(512, 5);
        chk_outs("R1 512", 4, 0, 0);
        blocks(128, 5);
        chk_outs("R6 128", 0, 0, 1);
        adc_active = 1'b1; #1;
        chk("R7 128 adc err", ratio_err, 1);
        adc_osr_force = 1'b1; #1;
        chk("R8 force on", adc_osr_64, 1);
        chk("R8 code unchanged", ratio_code, 0);
        adc_active = 1'b0; adc_osr_force = 1'b0; #1;
        chk("R8 force off", adc_osr_64, 0);
        blocks(192, 5);
        chk_outs("R6 192", 1, 0, 1);
    endtask

    task automatic t_windows;
        blocks(288, 5);
        chk_outs("R2 288 upper edge", 2, 0, 0);
        blocks(289, 5);
        chk_outs("R3 289 no match", 5, 1, 0);
        blocks(224, 5);
        chk_outs("R2 224 lower wins", 1, 0, 1);
        blocks(160, 5);
        chk_outs("R2 160 lower wins", 0, 0, 1);
        blocks(352, 5);
        chk_outs("R2 352 lower edge", 3, 0, 0);
        blocks(740, 5);
        chk_outs("R2 740", 5, 0, 0);
        blocks(1000, 5);
        chk_outs("R3 1000 no match", 5, 1, 0);
    endtask

    task automatic t_outlier;
        blocks(384, 5);
        chk_outs("R4 lock 384", 3, 0, 0);
        blocks(512, 1);
        blocks(384, 1);
        chk("R4 single outlier", ratio_code, 3);
        blocks(384, 1);
        chk("R4 after outlier", ratio_code, 3);
        blocks(512, 2);
        chk("R4 one new period", ratio_code, 3);
        blocks(512, 1);
        chk("R4 two new periods", ratio_code, 4);
    endtask

    task automatic t_master;
        master_mode = 1'b1; rate_sel = 3'd3; #1;
        chk_outs("R5 master 384", 3, 0, 0);
        blocks(128, 4);
        chk_outs("R5 wclk ignored", 3, 0, 0);
        rate_sel = 3'd1; #1;
        chk_outs("R5 master 192", 1, 0, 1);
        adc_active = 1'b1; #1;
        chk("R7 master adc err", ratio_err, 1);
        adc_active = 1'b0;
        rate_sel = 3'd7; #1;
        chk_outs("R5 master bad field", 5, 1, 0);
        master_mode = 1'b0; #1;
        chk("R10 committed kept", ratio_code, 4);
        blocks(256, 2);
        chk("R10 first period discarded", ratio_code, 4);
        blocks(256, 1);
        chk("R10 lock after agree", ratio_code, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_lock_basic();
        t_windows();
        t_outlier();
        t_master();
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule